// File: doc/BRIEF.md
# Banked General Register File with Status Control

This block is the general-purpose register storage of a processor core. It holds sixteen 32-bit logical registers. The upper eight are one set of storage that every context shares. The lower eight have two physical copies, called bank 0 and bank 1. A small status register holds three control bits: a privilege flag, a bank selector and an interrupt-block flag. The privilege flag and the bank selector together decide which copy of the lower eight registers the operand ports reach.

The execution pipeline reads two operands and writes one result through the normal ports. Privileged handlers also have an alternate port, which reaches the lower-eight copy that is not currently live. Through it they can save or restore the other context without switching banks. A reset input and an exception-entry input both force all three status bits to 1. The interrupt-block bit is driven out as an interrupt-mask signal for the request logic.

Top module: `banked_regfile`

## Requirements
- R1: In the status word, bit 30 is the privilege flag (1 = privileged), bit 29 is the bank selector and bit 28 is the interrupt-block flag. Every other bit reads 0, and the values written to those bits are ignored.
- R2: After a synchronous reset the status word reads 0x7000_0000.
- R3: When exception entry is asserted at a rising edge, the status word reads 0x7000_0000 after that edge. This holds even if a status write is requested in the same cycle.
- R4: A status write takes effect at the rising edge only if the privilege flag is 1 before that edge. In user mode the write is ignored.
- R5: `irq_mask` is 1 exactly when the interrupt-block flag is 1.
- R6: Registers 8 to 15 are a single copy, and their contents read the same in every mode and under every bank selection.
- R7: In privileged mode, registers 0 to 7 map to bank 0 when the bank selector is 0 and to bank 1 when it is 1.
- R8: In user mode, registers 0 to 7 map to bank 0, whatever the bank selector holds. This applies to both reads and writes.
- R9: In privileged mode, the alternate port reads and writes index 0 to 7 of the bank that is not live.
- R10: In user mode, the alternate port reads 0 and its writes change no register.
- R11: Reads are combinational. A write appears at the read ports after the rising edge, and before that edge the old value is read. A register write uses the bank mapping in force before the edge, even when a status write in the same cycle changes that mapping.
- R12: `priv_mode` follows the privilege flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exc_entry | input | 1 | Exception entry; forces the status bits to 1 |
| rs1_addr | input | 4 | Operand A register index |
| rs1_data | output | 32 | Operand A value |
| rs2_addr | input | 4 | Operand B register index |
| rs2_data | output | 32 | Operand B value |
| wr_en | input | 1 | Result write enable |
| wr_addr | input | 4 | Result register index |
| wr_data | input | 32 | Result value |
| alt_rd_addr | input | 3 | Alternate-bank read index |
| alt_rd_data | output | 32 | Alternate-bank read value |
| alt_wr_en | input | 1 | Alternate-bank write enable |
| alt_wr_addr | input | 3 | Alternate-bank write index |
| alt_wr_data | input | 32 | Alternate-bank write value |
| sr_wr_en | input | 1 | Status write enable |
| sr_wr_data | input | 32 | Status write value |
| sr_rd_data | output | 32 | Status word |
| irq_mask | output | 1 | Interrupt and break mask |
| priv_mode | output | 1 | Privilege flag |

## Verification
The assertions check the status rules on every cycle: values forced by reset and by exception entry, and status writes ignored in user mode. They also check the address mapping on every cycle: user mode lands in bank 0, the alternate port never reaches the live copy, and the shared indices stay outside the banks. Two things need the bench's scenarios because they rest on stored data: that a value written through one bank is seen through the alternate port or after a bank switch, and that alternate writes dropped in user mode left the data unchanged. The same applies to the write-before-switch ordering.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  // Status bit positions; the rest of the core decodes these.
  localparam int SR_PRIV_POS  = 30;
  localparam int SR_BANK_POS  = 29;
  localparam int SR_BLOCK_POS = 28;

  typedef struct packed {
    logic priv;
    logic bank;
    logic block;
  } sr_ctl_t;

  localparam sr_ctl_t SR_FORCED = '{priv: 1'b1, bank: 1'b1, block: 1'b1};
endpackage

// File: rtl/rb_status_reg.sv
module rb_status_reg
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_entry,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output sr_ctl_t           ctl
);
  sr_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= SR_FORCED;
    end else if (exc_entry) begin
      ctl_q <= SR_FORCED;
    end else if (wr_en && ctl_q.priv) begin
      ctl_q.priv  <= wr_data[SR_PRIV_POS];
      ctl_q.bank  <= wr_data[SR_BANK_POS];
      ctl_q.block <= wr_data[SR_BLOCK_POS];
    end
  end

  assign ctl = ctl_q;

  a_r2_reset_forces: assert property (@(posedge clk)
    rst |=> (ctl_q == SR_FORCED));

  a_r3_exception_forces: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> (ctl_q == SR_FORCED));

  a_r4_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.priv && !exc_entry) |=> $stable(ctl_q));
endmodule

// File: rtl/rb_bank_map.sv
module rb_bank_map #(
  parameter int NREG = 16,
  parameter int NB   = 8,
  parameter bit ALT  = 1'b0,
  parameter int AW   = 4,
  parameter int PW   = 5
) (
  input  logic          priv,
  input  logic          bank,
  input  logic [AW-1:0] addr,
  output logic [PW-1:0] phys
);
  localparam logic [AW-1:0] NB_A     = AW'(NB);
  localparam logic [PW-1:0] BANK_OFS = PW'(NB);
  localparam logic [PW-1:0] SHR_OFS  = PW'(2 * NB);

  logic live_bank;
  logic sel_bank;

  assign live_bank = priv & bank;

  generate
    if (ALT) begin : g_alt
      assign sel_bank = ~live_bank;
    end else begin : g_live
      assign sel_bank = live_bank;
    end
  endgenerate

  always_comb begin
    if (addr < NB_A) begin
      phys = (sel_bank ? BANK_OFS : '0) + PW'(addr);
    end else begin
      phys = SHR_OFS + PW'(addr - NB_A);
    end
  end
endmodule

// File: rtl/rb_reg_array.sv
module rb_reg_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 24,
  parameter int PW    = 5,
  parameter int NRD   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we_a,
  input  logic [PW-1:0]           wa_a,
  input  logic [DW-1:0]           wd_a,
  input  logic                    we_b,
  input  logic [PW-1:0]           wa_b,
  input  logic [DW-1:0]           wd_b,
  input  logic [NRD-1:0][PW-1:0]  ra,
  output logic [NRD-1:0][DW-1:0]  rd
);
  logic [DW-1:0] mem [DEPTH];

  // Storage is never cleared; port A wins a same-entry collision.
  always_ff @(posedge clk) begin
    if (we_b && !(we_a && (wa_a == wa_b))) begin
      mem[wa_b] <= wd_b;
    end
    if (we_a) begin
      mem[wa_a] <= wd_a;
    end
  end

  generate
    for (genvar i = 0; i < NRD; i++) begin : g_rd
      assign rd[i] = mem[ra[i]];
    end
  endgenerate

  // R11: a port-A write is what the entry holds after the edge
  a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
    we_a |=> (mem[$past(wa_a)] == $past(wd_a)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int NB     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       exc_entry,
  input  logic [$clog2(NREG)-1:0]    rs1_addr,
  output logic [DATA_W-1:0]          rs1_data,
  input  logic [$clog2(NREG)-1:0]    rs2_addr,
  output logic [DATA_W-1:0]          rs2_data,
  input  logic                       wr_en,
  input  logic [$clog2(NREG)-1:0]    wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [$clog2(NB)-1:0]      alt_rd_addr,
  output logic [DATA_W-1:0]          alt_rd_data,
  input  logic                       alt_wr_en,
  input  logic [$clog2(NB)-1:0]      alt_wr_addr,
  input  logic [DATA_W-1:0]          alt_wr_data,
  input  logic                       sr_wr_en,
  input  logic [DATA_W-1:0]          sr_wr_data,
  output logic [DATA_W-1:0]          sr_rd_data,
  output logic                       irq_mask,
  output logic                       priv_mode
);
  localparam int AW    = $clog2(NREG);
  localparam int NPHYS = NREG + NB;
  localparam int PW    = $clog2(NPHYS);
  localparam int NLIVE = 3;
  localparam int NRD   = 3;
  localparam logic [AW-1:0] NB_A = AW'(NB);
  localparam logic [PW-1:0] SHR_P = PW'(2 * NB);

  sr_ctl_t ctl;

  rb_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .exc_entry (exc_entry),
    .wr_en     (sr_wr_en),
    .wr_data   (sr_wr_data),
    .ctl       (ctl)
  );

  // Live mappers: 0 = rs1, 1 = rs2, 2 = write
  logic [NLIVE-1:0][AW-1:0] live_addr;
  logic [NLIVE-1:0][PW-1:0] live_phys;
  assign live_addr = {wr_addr, rs2_addr, rs1_addr};

  generate
    for (genvar i = 0; i < NLIVE; i++) begin : g_live_map
      rb_bank_map #(.NREG(NREG), .NB(NB), .ALT(1'b0), .AW(AW), .PW(PW)) u_map (
        .priv (ctl.priv),
        .bank (ctl.bank),
        .addr (live_addr[i]),
        .phys (live_phys[i])
      );
    end
  endgenerate

  // Alternate mappers: 0 = read, 1 = write
  logic [1:0][AW-1:0] alt_addr;
  logic [1:0][PW-1:0] alt_phys;
  assign alt_addr = {AW'(alt_wr_addr), AW'(alt_rd_addr)};

  generate
    for (genvar j = 0; j < 2; j++) begin : g_alt_map
      rb_bank_map #(.NREG(NREG), .NB(NB), .ALT(1'b1), .AW(AW), .PW(PW)) u_map (
        .priv (ctl.priv),
        .bank (ctl.bank),
        .addr (alt_addr[j]),
        .phys (alt_phys[j])
      );
    end
  endgenerate

  logic                      alt_we;
  logic [NRD-1:0][PW-1:0]    rd_phys;
  logic [NRD-1:0][DATA_W-1:0] rd_word;

  assign alt_we  = alt_wr_en & ctl.priv;
  assign rd_phys = {alt_phys[0], live_phys[1], live_phys[0]};

  rb_reg_array #(.DW(DATA_W), .DEPTH(NPHYS), .PW(PW), .NRD(NRD)) u_array (
    .clk  (clk),
    .rst  (rst),
    .we_a (wr_en),
    .wa_a (live_phys[2]),
    .wd_a (wr_data),
    .we_b (alt_we),
    .wa_b (alt_phys[1]),
    .wd_b (alt_wr_data),
    .ra   (rd_phys),
    .rd   (rd_word)
  );

  assign rs1_data    = rd_word[0];
  assign rs2_data    = rd_word[1];
  assign alt_rd_data = ctl.priv ? rd_word[2] : '0;

  always_comb begin
    sr_rd_data               = '0;
    sr_rd_data[SR_PRIV_POS]  = ctl.priv;
    sr_rd_data[SR_BANK_POS]  = ctl.bank;
    sr_rd_data[SR_BLOCK_POS] = ctl.block;
  end

  assign irq_mask  = ctl.block;
  assign priv_mode = ctl.priv;

  a_r8_user_bank0: assert property (@(posedge clk) disable iff (rst)
    (!priv_mode && (rs1_addr < NB_A)) |-> (live_phys[0] < PW'(NB)));

  a_r9_alt_not_live: assert property (@(posedge clk) disable iff (rst)
    (priv_mode && (rs1_addr == AW'(alt_rd_addr))) |-> (alt_phys[0] != live_phys[0]));

  a_r6_shared_outside_banks: assert property (@(posedge clk) disable iff (rst)
    (wr_addr >= NB_A) |-> (live_phys[2] >= SHR_P));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_entry = 1'b0;
  logic [3:0]  rs1_addr = '0, rs2_addr = '0, wr_addr = '0;
  logic [31:0] rs1_data, rs2_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  alt_rd_addr = '0, alt_wr_addr = '0;
  logic [31:0] alt_rd_data, alt_wr_data = '0;
  logic        alt_wr_en = 1'b0;
  logic        sr_wr_en = 1'b0;
  logic [31:0] sr_wr_data = '0, sr_rd_data;
  logic        irq_mask, priv_mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst(rst), .exc_entry(exc_entry),
    .rs1_addr(rs1_addr), .rs1_data(rs1_data),
    .rs2_addr(rs2_addr), .rs2_data(rs2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alt_rd_addr(alt_rd_addr), .alt_rd_data(alt_rd_data),
    .alt_wr_en(alt_wr_en), .alt_wr_addr(alt_wr_addr), .alt_wr_data(alt_wr_data),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
    .irq_mask(irq_mask), .priv_mode(priv_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic gpr_write(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic sr_write(input logic [31:0] d);
    sr_wr_en = 1'b1; sr_wr_data = d;
    tick();
    sr_wr_en = 1'b0;
  endtask

  task automatic alt_write(input logic [2:0] a, input logic [31:0] d);
    alt_wr_en = 1'b1; alt_wr_addr = a; alt_wr_data = d;
    tick();
    alt_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    #1;
    check("R2 status after reset", sr_rd_data, 32'h7000_0000);
    check("R5 mask after reset", {31'd0, irq_mask}, 32'd1);
    check("R12 privilege after reset", {31'd0, priv_mode}, 32'd1);
  endtask

  task automatic t_bank_select();
    gpr_write(4'd3, 32'hA1A1_0003);          // bank 1 live
    sr_write(32'h5000_0000);                 // bank 0 live
    gpr_write(4'd3, 32'hB0B0_0003);
    rs1_addr = 4'd3; alt_rd_addr = 3'd3; #1;
    check("R7 bank0 live read", rs1_data, 32'hB0B0_0003);
    check("R9 alt reads bank1", alt_rd_data, 32'hA1A1_0003);
    sr_write(32'h7000_0000);
    rs2_addr = 4'd3; #1;
    check("R7 bank1 live read", rs2_data, 32'hA1A1_0003);
    check("R9 alt reads bank0", alt_rd_data, 32'hB0B0_0003);
  endtask

  task automatic t_alt_write();
    alt_write(3'd5, 32'hC0C0_0005);          // bank 1 live -> lands in bank 0
    alt_rd_addr = 3'd5; #1;
    check("R9 alt write readback", alt_rd_data, 32'hC0C0_0005);
    sr_write(32'h5000_0000);
    rs1_addr = 4'd5; #1;
    check("R9 alt write seen in bank0", rs1_data, 32'hC0C0_0005);
    sr_write(32'h7000_0000);
  endtask

  task automatic t_shared();
    gpr_write(4'd10, 32'hDDDD_000A);
    sr_write(32'h5000_0000);
    rs1_addr = 4'd10; #1;
    check("R6 shared across banks", rs1_data, 32'hDDDD_000A);
  endtask

  task automatic t_reserved();
    sr_write(32'hFFFF_FFFF);
    check("R1 reserved bits read 0", sr_rd_data, 32'h7000_0000);
    sr_write(32'hCFFF_FFFF);
    check("R1 field positions", sr_rd_data, 32'h4000_0000);
    check("R5 mask cleared", {31'd0, irq_mask}, 32'd0);
  endtask

  task automatic t_user();
    sr_write(32'h2000_0000);                 // user mode, selector 1
    check("R12 user mode", {31'd0, priv_mode}, 32'd0);
    rs1_addr = 4'd3; rs2_addr = 4'd10; alt_rd_addr = 3'd3; #1;
    check("R8 user reads bank0", rs1_data, 32'hB0B0_0003);
    check("R6 shared in user mode", rs2_data, 32'hDDDD_000A);
    check("R10 alt read zero in user", alt_rd_data, 32'h0);
    alt_write(3'd3, 32'hEEEE_EEEE);
    sr_write(32'h7000_0000);
    check("R4 user status write ignored", sr_rd_data, 32'h2000_0000);
    gpr_write(4'd2, 32'hF0F0_0002);
    exc_entry = 1'b1; tick(); exc_entry = 1'b0;
    check("R3 exception forces bits", sr_rd_data, 32'h7000_0000);
    alt_rd_addr = 3'd3; #1;
    check("R10 user alt write dropped", alt_rd_data, 32'hB0B0_0003);
    alt_rd_addr = 3'd2; #1;
    check("R8 user write went to bank0", alt_rd_data, 32'hF0F0_0002);
  endtask

  task automatic t_exc_override();
    sr_wr_en = 1'b1; sr_wr_data = 32'h4000_0000; exc_entry = 1'b1;
    tick();
    sr_wr_en = 1'b0; exc_entry = 1'b0;
    check("R3 exception beats status write", sr_rd_data, 32'h7000_0000);
  endtask

  task automatic t_timing();
    gpr_write(4'd12, 32'h0000_0011);
    wr_en = 1'b1; wr_addr = 4'd12; wr_data = 32'h0000_0022; rs1_addr = 4'd12; #1;
    check("R11 old value before edge", rs1_data, 32'h0000_0011);
    tick(); wr_en = 1'b0;
    check("R11 new value after edge", rs1_data, 32'h0000_0022);
    // bank 1 live; switch and write in one cycle
    wr_en = 1'b1; wr_addr = 4'd4; wr_data = 32'h6666_0004;
    sr_wr_en = 1'b1; sr_wr_data = 32'h5000_0000;
    tick();
    wr_en = 1'b0; sr_wr_en = 1'b0;
    alt_rd_addr = 3'd4; #1;
    check("R11 write used old mapping", alt_rd_data, 32'h6666_0004);
  endtask

  initial begin
    t_reset();
    t_bank_select();
    t_alt_write();
    t_shared();
    t_reserved();
    t_user();
    t_exc_override();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule